// File: doc/BRIEF.md
# Configurable Logic Macrocell

This block is a behavioural model of one cell of a programmable logic array. A static configuration word, together with two mask vectors, sets everything the cell does. Five product terms are built from an input bus. Each term is the AND of any chosen set of true and inverted bus bits. A term with no bits selected evaluates to 1. Selector fields hand these terms out to the sum path, the XOR second operand, the register data input, and the register clock, clock-enable, asynchronous clear and asynchronous set. The same selectors also feed the output enable and a foldback output.

The storage element works in one of three modes: an edge-triggered D register, a toggle register, or a level-sensitive latch. The clock is either the global clock or a product term. Clearing comes from a global clear pin, from a term, from both, or from neither. Setting comes from a term or is disabled. The cell then chooses a registered or combinational pin value and a matching feedback value. It also chooses an output enable, and it drives out its sum for chaining into a neighbouring cell. Cells are chained through the cascade pins; the feedback and foldback outputs go back to the shared buses outside the block.

Top module: `pld_macrocell`

## Requirements
- R1: Term k (k = 0..4) is 1 when every bus bit set in `pt_true_i[k*IN_W +: IN_W]` is 1 and every bus bit set in `pt_comp_i[k*IN_W +: IN_W]` is 0. A term with no mask bits set is 1. A 3-bit term index of 5, 6 or 7 selects constant 0.
- R2: The sum is the OR of the terms whose `sum_mask` bit is set, ORed with `cas_i` when `cas_en` is 1. `cas_o` carries this sum.
- R3: The combinational value is the sum XOR a second operand chosen by `xor_mode`: 0 gives 0, 1 gives 1, 2 gives term `xor_pt`, and 3 gives 0.
- R4: The register data input is term `d_pt` when `d_from_pt` is 1, and the combinational value otherwise.
- R5: With `reg_mode` 0 (D, and also code 3) the register loads the data on a rising clock edge. With `reg_mode` 1 (toggle) it inverts on a rising edge when the data is 1 and holds when the data is 0.
- R6: With `reg_mode` 2 the storage is a latch. It follows the data while the selected clock is 1 and holds while the clock is 0.
- R7: The clock is `clk_i` when `clk_from_pt` is 0, and term `clk_pt` otherwise. Only with `clk_i`, and only when `ce_en` is 1, term `ce_pt` being 0 makes the register ignore rising edges.
- R8: `ar_mode` picks the asynchronous clear: 0 none, 1 `gclr_ni` low, 2 term `ar_pt`, 3 either of these. When the mode excludes a source, that source has no effect.
- R9: When `ap_en` is 1, term `ap_pt` asynchronously sets the register to 1. A clear that is active at the same time wins and holds the register at 0.
- R10: With `out_reg` 1, both `out_o` and `fb_o` show the register. With `out_reg` 0, `out_o` is the combinational value and `fb_o` is also the combinational value, except that it shows the register when both `fb_from_reg` and `d_from_pt` are 1.
- R11: `oe_mode` sets `oe_o`: 0 always 1, 1 always 0, 2 the inverse of `oe_n_i[0]`, 3 the inverse of `oe_n_i[1]`, 4 term `oe_pt`, and 5 to 7 give 0.
- R12: `fold_o` is the inverse of term `fold_pt`.
- R13: While `rst_ni` is low the register is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Global clock |
| rst_ni | input | 1 | Power-up reset, active low, asynchronous |
| gclr_ni | input | 1 | Global clear pin, active low |
| oe_n_i | input | 2 | Global output-enable pins, active low |
| bus_i | input | IN_W | Input bus from which the product terms are formed |
| pt_true_i | input | 5*IN_W | Per-term mask of bus bits used in true form |
| pt_comp_i | input | 5*IN_W | Per-term mask of bus bits used in inverted form |
| cas_i | input | 1 | Cascade sum from the neighbouring cell |
| cfg_i | input | CFG_W | Packed configuration word (`mc_cfg_t`) |
| out_o | output | 1 | Pin data value |
| oe_o | output | 1 | Pin output enable |
| fb_o | output | 1 | Buried feedback value |
| fold_o | output | 1 | Foldback term (inverted selected term) |
| cas_o | output | 1 | Cascade sum to the next cell |

## Verification
The hardest case to reach is a register clocked by a product term. There, a bus change can move the clock and the data together, and the model would then depend on event order. The random phase therefore ties the clock term to bus bit 0 alone and keeps bit 0 out of every data-path term. It toggles bit 0 in steps of its own, apart from the other bits. A second hard case is clear and set overlapping and then being released one at a time. Directed steps drive both through dedicated bus bits and read the register back through the registered output.

// File: rtl/mc_pkg.sv
package mc_pkg;
  localparam int NUM_PT   = 5;
  localparam int PT_IDX_W = 3;

  typedef enum logic [1:0] {XOR_ZERO = 2'd0, XOR_ONE = 2'd1, XOR_TERM = 2'd2, XOR_RSVD = 2'd3} xor_mode_e;
  typedef enum logic [1:0] {RM_D = 2'd0, RM_T = 2'd1, RM_LATCH = 2'd2, RM_RSVD = 2'd3} reg_mode_e;
  typedef enum logic [1:0] {AR_OFF = 2'd0, AR_GCLR = 2'd1, AR_TERM = 2'd2, AR_BOTH = 2'd3} ar_mode_e;
  typedef enum logic [2:0] {OE_ON = 3'd0, OE_OFF = 3'd1, OE_PIN0 = 3'd2, OE_PIN1 = 3'd3, OE_TERM = 3'd4} oe_mode_e;

  typedef struct packed {
    logic [NUM_PT-1:0]   sum_mask;
    logic                cas_en;
    xor_mode_e           xor_mode;
    logic [PT_IDX_W-1:0] xor_pt;
    logic                d_from_pt;
    logic [PT_IDX_W-1:0] d_pt;
    reg_mode_e           reg_mode;
    logic                clk_from_pt;
    logic [PT_IDX_W-1:0] clk_pt;
    logic                ce_en;
    logic [PT_IDX_W-1:0] ce_pt;
    ar_mode_e            ar_mode;
    logic [PT_IDX_W-1:0] ar_pt;
    logic                ap_en;
    logic [PT_IDX_W-1:0] ap_pt;
    logic                out_reg;
    logic                fb_from_reg;
    oe_mode_e            oe_mode;
    logic [PT_IDX_W-1:0] oe_pt;
    logic [PT_IDX_W-1:0] fold_pt;
  } mc_cfg_t;

  localparam int CFG_W = $bits(mc_cfg_t);

  // out-of-range index yields constant 0
  function automatic logic pick_pt(input logic [NUM_PT-1:0] pt, input logic [PT_IDX_W-1:0] idx);
    return (idx < PT_IDX_W'(NUM_PT)) ? pt[idx] : 1'b0;
  endfunction
endpackage

// File: rtl/mc_pterm_array.sv
module mc_pterm_array
  import mc_pkg::*;
#(
  parameter int IN_W = 8
) (
  input  logic [IN_W-1:0]        bus_i,
  input  logic [NUM_PT*IN_W-1:0] true_mask_i,
  input  logic [NUM_PT*IN_W-1:0] comp_mask_i,
  output logic [NUM_PT-1:0]      pt_o
);
  for (genvar k = 0; k < NUM_PT; k++) begin : g_pt
    logic [IN_W-1:0] tm, cm;
    assign tm = true_mask_i[k*IN_W +: IN_W];
    assign cm = comp_mask_i[k*IN_W +: IN_W];
    assign pt_o[k] = (&(bus_i | ~tm)) & (&(~bus_i | ~cm));
  end
endmodule

// File: rtl/mc_sum_xor.sv
module mc_sum_xor
  import mc_pkg::*;
(
  input  logic [NUM_PT-1:0]   pt_i,
  input  logic [NUM_PT-1:0]   sum_mask_i,
  input  logic                cas_en_i,
  input  logic                cas_i,
  input  xor_mode_e           xor_mode_i,
  input  logic [PT_IDX_W-1:0] xor_pt_i,
  output logic                sum_o,
  output logic                comb_o
);
  logic xor_b;

  assign sum_o = (|(pt_i & sum_mask_i)) | (cas_en_i & cas_i);

  always_comb begin
    case (xor_mode_i)
      XOR_ONE:  xor_b = 1'b1;
      XOR_TERM: xor_b = pick_pt(pt_i, xor_pt_i);
      default:  xor_b = 1'b0;
    endcase
  end

  assign comb_o = sum_o ^ xor_b;
endmodule

// File: rtl/mc_storage.sv
module mc_storage
  import mc_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                gclr_ni,
  input  logic [NUM_PT-1:0]   pt_i,
  input  logic                d_i,
  input  reg_mode_e           reg_mode_i,
  input  logic                clk_from_pt_i,
  input  logic [PT_IDX_W-1:0] clk_pt_i,
  input  logic                ce_en_i,
  input  logic [PT_IDX_W-1:0] ce_pt_i,
  input  ar_mode_e            ar_mode_i,
  input  logic [PT_IDX_W-1:0] ar_pt_i,
  input  logic                ap_en_i,
  input  logic [PT_IDX_W-1:0] ap_pt_i,
  output logic                q_o,
  output logic                ar_act_o,
  output logic                ap_act_o,
  output logic                ce_term_o
);
  logic rclk, ce_ok, clr, set, nxt, q_ff, q_lat;

  assign rclk      = clk_from_pt_i ? pick_pt(pt_i, clk_pt_i) : clk_i;
  assign ce_term_o = pick_pt(pt_i, ce_pt_i);
  assign ce_ok     = clk_from_pt_i | ~ce_en_i | ce_term_o;

  always_comb begin
    case (ar_mode_i)
      AR_GCLR: ar_act_o = ~gclr_ni;
      AR_TERM: ar_act_o = pick_pt(pt_i, ar_pt_i);
      AR_BOTH: ar_act_o = ~gclr_ni | pick_pt(pt_i, ar_pt_i);
      default: ar_act_o = 1'b0;
    endcase
  end

  assign ap_act_o = ap_en_i & pick_pt(pt_i, ap_pt_i);
  assign clr      = ~rst_ni | ar_act_o;
  // set gated by clear so releasing clear under an active set re-triggers
  assign set      = ap_act_o & ~clr;
  assign nxt      = (reg_mode_i == RM_T) ? (q_ff ^ d_i) : d_i;

  always_ff @(posedge rclk or posedge clr or posedge set) begin
    if (clr)        q_ff <= 1'b0;
    else if (set)   q_ff <= 1'b1;
    else if (ce_ok) q_ff <= nxt;
  end

  always_latch begin
    if (clr)       q_lat = 1'b0;
    else if (set)  q_lat = 1'b1;
    else if (rclk) q_lat = d_i;
  end

  assign q_o = (reg_mode_i == RM_LATCH) ? q_lat : q_ff;
endmodule

// File: rtl/pld_macrocell.sv
module pld_macrocell
  import mc_pkg::*;
#(
  parameter int IN_W = 8
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   gclr_ni,
  input  logic [1:0]             oe_n_i,
  input  logic [IN_W-1:0]        bus_i,
  input  logic [NUM_PT*IN_W-1:0] pt_true_i,
  input  logic [NUM_PT*IN_W-1:0] pt_comp_i,
  input  logic                   cas_i,
  input  logic [CFG_W-1:0]       cfg_i,
  output logic                   out_o,
  output logic                   oe_o,
  output logic                   fb_o,
  output logic                   fold_o,
  output logic                   cas_o
);
  mc_cfg_t           cfg;
  logic [NUM_PT-1:0] pt;
  logic              comb, d_val, reg_q, ar_act, ap_act, ce_term;

  assign cfg = mc_cfg_t'(cfg_i);

  mc_pterm_array #(.IN_W(IN_W)) u_pt (
    .bus_i       (bus_i),
    .true_mask_i (pt_true_i),
    .comp_mask_i (pt_comp_i),
    .pt_o        (pt)
  );

  mc_sum_xor u_sum (
    .pt_i       (pt),
    .sum_mask_i (cfg.sum_mask),
    .cas_en_i   (cfg.cas_en),
    .cas_i      (cas_i),
    .xor_mode_i (cfg.xor_mode),
    .xor_pt_i   (cfg.xor_pt),
    .sum_o      (cas_o),
    .comb_o     (comb)
  );

  assign d_val = cfg.d_from_pt ? pick_pt(pt, cfg.d_pt) : comb;

  mc_storage u_reg (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .gclr_ni       (gclr_ni),
    .pt_i          (pt),
    .d_i           (d_val),
    .reg_mode_i    (cfg.reg_mode),
    .clk_from_pt_i (cfg.clk_from_pt),
    .clk_pt_i      (cfg.clk_pt),
    .ce_en_i       (cfg.ce_en),
    .ce_pt_i       (cfg.ce_pt),
    .ar_mode_i     (cfg.ar_mode),
    .ar_pt_i       (cfg.ar_pt),
    .ap_en_i       (cfg.ap_en),
    .ap_pt_i       (cfg.ap_pt),
    .q_o           (reg_q),
    .ar_act_o      (ar_act),
    .ap_act_o      (ap_act),
    .ce_term_o     (ce_term)
  );

  assign out_o  = cfg.out_reg ? reg_q : comb;
  assign fb_o   = (cfg.out_reg || (cfg.fb_from_reg && cfg.d_from_pt)) ? reg_q : comb;
  assign fold_o = ~pick_pt(pt, cfg.fold_pt);

  always_comb begin
    case (cfg.oe_mode)
      OE_ON:   oe_o = 1'b1;
      OE_PIN0: oe_o = ~oe_n_i[0];
      OE_PIN1: oe_o = ~oe_n_i[1];
      OE_TERM: oe_o = pick_pt(pt, cfg.oe_pt);
      default: oe_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/pld_macrocell_chk.sv
module pld_macrocell_chk
  import mc_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input mc_cfg_t    cfg,
  input logic       reg_q,
  input logic       ar_act,
  input logic       ap_act,
  input logic       ce_term,
  input logic       d_val,
  input logic       cas_i,
  input logic       cas_o,
  input logic [1:0] oe_n_i,
  input logic       oe_o,
  input logic       out_o,
  input logic       fb_o
);
  // R9
  reset_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ar_act |-> !reg_q);

  // R9
  preset_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ap_act && !ar_act) |-> reg_q);

  // R7
  ce_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg.clk_from_pt && cfg.reg_mode != RM_LATCH && cfg.ce_en && !ce_term && !ar_act && !ap_act)
    |=> (ar_act || ap_act || cfg != $past(cfg) || reg_q == $past(reg_q)));

  // R5
  toggle_flip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg.clk_from_pt && cfg.reg_mode == RM_T && (!cfg.ce_en || ce_term) && d_val && !ar_act && !ap_act)
    |=> (ar_act || ap_act || cfg != $past(cfg) || reg_q != $past(reg_q)));

  // R2
  cascade_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg.cas_en && cas_i) |-> cas_o);

  // R11
  oe_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg.oe_mode == OE_OFF) |-> !oe_o);

  // R11
  oe_pin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg.oe_mode == OE_PIN0) |-> (oe_o == !oe_n_i[0]));

  // R10
  reg_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg.out_reg |-> (out_o == reg_q && fb_o == reg_q));
endmodule

bind pld_macrocell pld_macrocell_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .cfg     (cfg),
  .reg_q   (reg_q),
  .ar_act  (ar_act),
  .ap_act  (ap_act),
  .ce_term (ce_term),
  .d_val   (d_val),
  .cas_i   (cas_i),
  .cas_o   (cas_o),
  .oe_n_i  (oe_n_i),
  .oe_o    (oe_o),
  .out_o   (out_o),
  .fb_o    (fb_o)
);

// File: tb/sim_pld_macrocell.sv
`timescale 1ns/1ps
module sim_pld_macrocell;
  import mc_pkg::*;
  localparam int IN_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0, gclr_n = 1'b1, cas = 1'b0;
  logic [1:0] oe_n = 2'b11;
  logic [IN_W-1:0] bus = '0;
  logic [NUM_PT*IN_W-1:0] tmask = '0, cmask = '0;
  mc_cfg_t cfg = '0;

  logic n_rst = 1'b0, n_gclr = 1'b1, n_cas = 1'b0;
  logic [1:0] n_oe = 2'b11;
  logic [IN_W-1:0] n_bus = '0;
  logic [NUM_PT*IN_W-1:0] n_t = '0, n_c = '0;
  mc_cfg_t n_cfg = '0;

  logic out_w, oe_w, fb_w, fold_w, cas_w;
  logic mq = 1'b0, clk_prev = 1'b0;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  pld_macrocell #(.IN_W(IN_W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .gclr_ni(gclr_n), .oe_n_i(oe_n), .bus_i(bus),
    .pt_true_i(tmask), .pt_comp_i(cmask), .cas_i(cas), .cfg_i(cfg),
    .out_o(out_w), .oe_o(oe_w), .fb_o(fb_w), .fold_o(fold_w), .cas_o(cas_w)
  );

  always #2.5 clk = ~clk;

  function automatic logic [NUM_PT-1:0] b_pts();
    logic [NUM_PT-1:0] p;
    for (int k = 0; k < NUM_PT; k++) begin
      logic [IN_W-1:0] t, c;
      t = tmask[k*IN_W +: IN_W];
      c = cmask[k*IN_W +: IN_W];
      p[k] = ((bus & t) == t) && ((~bus & c) == c);
    end
    return p;
  endfunction

  function automatic logic b_pick(logic [NUM_PT-1:0] p, logic [2:0] i);
    return (i < 3'd5) ? p[i] : 1'b0;
  endfunction

  function automatic logic b_sum(logic [NUM_PT-1:0] p);
    return (|(p & cfg.sum_mask)) | (cfg.cas_en & cas);
  endfunction

  function automatic logic b_comb(logic [NUM_PT-1:0] p);
    logic x;
    x = (cfg.xor_mode == XOR_ONE) ? 1'b1 :
        (cfg.xor_mode == XOR_TERM) ? b_pick(p, cfg.xor_pt) : 1'b0;
    return b_sum(p) ^ x;
  endfunction

  function automatic logic b_d(logic [NUM_PT-1:0] p);
    return cfg.d_from_pt ? b_pick(p, cfg.d_pt) : b_comb(p);
  endfunction

  function automatic logic b_ar(logic [NUM_PT-1:0] p);
    case (cfg.ar_mode)
      AR_GCLR: return !gclr_n;
      AR_TERM: return b_pick(p, cfg.ar_pt);
      AR_BOTH: return !gclr_n || b_pick(p, cfg.ar_pt);
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic b_nxt(logic [NUM_PT-1:0] p);
    return (cfg.reg_mode == RM_T) ? (mq ^ b_d(p)) : b_d(p);
  endfunction

  task automatic model_async();
    logic [NUM_PT-1:0] p;
    logic rc, lat;
    p = b_pts();
    rc = cfg.clk_from_pt ? b_pick(p, cfg.clk_pt) : clk;
    lat = (cfg.reg_mode == RM_LATCH);
    if (!rst_n || b_ar(p)) mq = 1'b0;
    else if (cfg.ap_en && b_pick(p, cfg.ap_pt)) mq = 1'b1;
    else if (lat && rc) mq = b_d(p);
    else if (!lat && cfg.clk_from_pt && rc && !clk_prev) mq = b_nxt(p);
    clk_prev = rc;
  endtask

  task automatic model_posedge();
    logic [NUM_PT-1:0] p;
    p = b_pts();
    if (rst_n && !b_ar(p) && !(cfg.ap_en && b_pick(p, cfg.ap_pt)) && !cfg.clk_from_pt) begin
      if (cfg.reg_mode == RM_LATCH) mq = b_d(p);
      else if (!cfg.ce_en || b_pick(p, cfg.ce_pt)) mq = b_nxt(p);
    end
  endtask

  task automatic chk(string tag, string what, logic act, logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %b expected %b", tag, what, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    logic [NUM_PT-1:0] p;
    logic e_out, e_fb, e_oe;
    string t_out;
    p = b_pts();
    e_out = cfg.out_reg ? mq : b_comb(p);
    e_fb = (cfg.out_reg || (cfg.fb_from_reg && cfg.d_from_pt)) ? mq : b_comb(p);
    case (cfg.oe_mode)
      OE_ON:   e_oe = 1'b1;
      OE_PIN0: e_oe = !oe_n[0];
      OE_PIN1: e_oe = !oe_n[1];
      OE_TERM: e_oe = b_pick(p, cfg.oe_pt);
      default: e_oe = 1'b0;
    endcase
    if (tag != "") t_out = tag;
    else if (!cfg.out_reg) t_out = "R3";
    else if (cfg.reg_mode == RM_LATCH) t_out = "R6";
    else t_out = "R5";
    chk(t_out, "out_o", out_w, e_out);
    chk(tag != "" ? tag : "R10", "fb_o", fb_w, e_fb);
    chk(tag != "" ? tag : "R11", "oe_o", oe_w, e_oe);
    chk(tag != "" ? tag : "R12", "fold_o", fold_w, !b_pick(p, cfg.fold_pt));
    chk(tag != "" ? tag : "R2", "cas_o", cas_w, b_sum(p));
  endtask

  // one cycle: drive after the falling edge, check, then check after the rising edge
  task automatic step(string tag);
    @(negedge clk);
    #0.5;
    rst_n = n_rst; gclr_n = n_gclr; oe_n = n_oe; bus = n_bus; cas = n_cas;
    cfg = n_cfg; tmask = n_t; cmask = n_c;
    #0.5;
    model_async();
    check_all(tag);
    @(posedge clk);
    #0.5;
    model_posedge();
    check_all(tag);
  endtask

  task automatic base_cfg();
    n_cfg = '0;
    n_t = '0;
    n_c = '0;
    for (int k = 0; k < NUM_PT; k++) n_t[k*IN_W + k + 1] = 1'b1; // term k = bus bit k+1
    n_cfg.out_reg = 1'b1;
    n_cfg.d_from_pt = 1'b1; n_cfg.d_pt = 3'd0;
    n_cfg.ce_en = 1'b1;     n_cfg.ce_pt = 3'd1;
    n_cfg.ar_mode = AR_BOTH; n_cfg.ar_pt = 3'd2;
    n_cfg.ap_en = 1'b1;     n_cfg.ap_pt = 3'd3;
    n_cfg.oe_mode = OE_ON;  n_cfg.fold_pt = 3'd4;
  endtask

  task automatic rand_cfg(bit term_clk);
    n_cfg = mc_cfg_t'({$urandom, $urandom});
    n_cfg.xor_mode = xor_mode_e'($urandom % 4);
    n_cfg.reg_mode = reg_mode_e'($urandom % 4);
    n_cfg.ar_mode = ar_mode_e'($urandom % 4);
    n_cfg.oe_mode = oe_mode_e'($urandom % 6);
    n_cfg.xor_pt = 3'($urandom % 6); n_cfg.d_pt = 3'($urandom % 6);
    n_cfg.ce_pt = 3'($urandom % 6);  n_cfg.ar_pt = 3'($urandom % 6);
    n_cfg.ap_pt = 3'($urandom % 6);  n_cfg.oe_pt = 3'($urandom % 6);
    n_cfg.fold_pt = 3'($urandom % 6); n_cfg.clk_pt = 3'($urandom % 6);
    n_cfg.clk_from_pt = term_clk;
    n_t = '0;
    n_c = '0;
    for (int k = 0; k < NUM_PT; k++)
      for (int b = 0; b < IN_W; b++) begin
        int r;
        r = $urandom % 8;
        if (term_clk && (b == 0 || k == 4)) r = 7;
        if (r == 0) n_t[k*IN_W + b] = 1'b1;
        else if (r == 1) n_c[k*IN_W + b] = 1'b1;
      end
    if (term_clk) begin
      // term 4 is the clock and depends on bus bit 0 only
      n_t[4*IN_W] = 1'b1;
      n_cfg.clk_pt = 3'd4;
      n_cfg.sum_mask[4] = 1'b0;
      n_cfg.xor_pt = 3'($urandom % 4);
      n_cfg.d_pt = 3'($urandom % 4);
      n_cfg.ce_pt = 3'($urandom % 4);
    end
  endtask

  initial begin
    void'($urandom(32'h1a2b3c4d));
    // R13: reset holds the register low
    base_cfg();
    n_rst = 1'b0; n_bus = 8'b0000_0110;
    step("R13");
    n_rst = 1'b1;
    step("R5");                         // D load of 1
    n_bus = 8'b0000_0000; step("R7");   // enable low, hold 1
    n_gclr = 1'b0; step("R8");          // global clear
    n_gclr = 1'b1; n_bus = 8'b0000_0110; step("R5");
    n_bus = 8'b0001_1110; step("R9");   // clear and set together: 0
    n_bus = 8'b0001_0110; step("R9");   // set alone: 1
    n_cfg.ar_mode = AR_OFF; n_gclr = 1'b0; n_bus = 8'b0000_0000;
    step("R8");                         // clear pin excluded: stays 1
    n_gclr = 1'b1; n_cfg.reg_mode = RM_T; n_bus = 8'b0000_0110;
    step("R5"); step("R5");             // toggles 0 then 1
    n_cfg.reg_mode = RM_D; n_cfg.out_reg = 1'b0; n_cfg.fb_from_reg = 1'b1;
    n_cfg.sum_mask = 5'b10000;
    n_bus = 8'b0010_0000; step("R4");
    n_bus = 8'b0010_0100; step("R4");   // comb 1, register loads 0
    n_cfg.xor_mode = XOR_ONE; n_bus = 8'b0010_0000; step("R3");
    n_cfg.xor_mode = XOR_TERM; n_cfg.xor_pt = 3'd0; n_bus = 8'b0010_0010; step("R3");
    n_cfg.oe_mode = OE_PIN1; n_oe = 2'b01; step("R11");
    n_cfg.oe_mode = OE_TERM; n_cfg.oe_pt = 3'd4; step("R11");
    n_cfg.fold_pt = 3'd5; step("R12");
    n_cfg.cas_en = 1'b1; n_cas = 1'b1; n_cfg.sum_mask = 5'b00000; step("R2");
    // R1: term 0 = bit1 & bit2 & ~bit3; empty term is 1
    n_cas = 1'b0; n_cfg.xor_mode = XOR_ZERO; n_cfg.sum_mask = 5'b00001;
    n_t[IN_W-1:0] = 8'b0000_0110; n_c[IN_W-1:0] = 8'b0000_1000;
    n_bus = 8'b0000_0110; step("R1");
    n_bus = 8'b0000_1110; step("R1");
    n_bus = 8'b0000_0010; step("R1");
    n_t[2*IN_W-1:IN_W] = '0; n_cfg.sum_mask = 5'b00010; n_bus = 8'b0000_0000; step("R1");
    // R6: latch follows while clock high, holds while low
    base_cfg(); n_rst = 1'b0; n_bus = '0; step("R13");
    n_rst = 1'b1; n_cfg.reg_mode = RM_LATCH; n_bus = 8'b0000_0010; step("R6");
    n_bus = 8'b0000_0000; step("R6");
    // R7: product-term clock on bit 5, enable ignored
    base_cfg(); n_cfg.clk_from_pt = 1'b1; n_cfg.clk_pt = 3'd4;
    n_rst = 1'b0; n_bus = '0; step("R13");
    n_rst = 1'b1; n_bus = 8'b0000_0010; step("R7");
    n_bus = 8'b0010_0010; step("R7");   // term clock rises: loads 1
    n_bus = 8'b0010_0000; step("R7");   // clock stays high: holds
    n_bus = 8'b0000_0000; step("R7");
    n_bus = 8'b0010_0000; step("R7");   // rises: loads 0
    // random configurations
    for (int c = 0; c < 60; c++) begin
      bit tc;
      tc = (c % 3 == 2);
      rand_cfg(tc);
      n_rst = 1'b0; n_bus = IN_W'($urandom); n_gclr = 1'b1;
      step("");
      n_rst = 1'b1;
      for (int s = 0; s < 30; s++) begin
        if (tc && s[0]) begin
          n_bus[0] = ~n_bus[0];
        end else begin
          logic b0;
          b0 = n_bus[0];
          n_bus = IN_W'($urandom);
          if (tc) n_bus[0] = b0;
          n_gclr = ($urandom % 8) != 0;
          n_oe = 2'($urandom);
          n_cas = 1'($urandom);
        end
        step("");
      end
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule